// File: doc/BRIEF.md
# Prioritized Reset Request Controller

This controller decides which of four reset requests acts on a processor core and on the board around it. It also tracks the core's health state. Two requests arrive from outside the core. The first is power-on, which also covers a push-button reset. The second is an externally initiated reset. The other two start inside the core. A watchdog reset is raised when the core falls into its error state. A software reset is raised when a program asks for one.

The core's health state is one of normal, error or red (recovery). The controller enters the error state when a trap arrives while the trap level is one short of the maximum. That entry raises the watchdog request.

Power-on is the only request that resets the whole board. It holds the board reset for a fixed count of cycles after the request goes away, and then returns the core to normal. The three other requests reset only the core and leave register contents alone. The externally initiated and watchdog resets move a core that is in the error state to red. Power-on and watchdog resets also emit a one-cycle strobe that cancels pending transactions. A cause register keeps a one-hot record of the most recently taken reset.

Top module: `reset_request_ctrl`

## Requirements
- R1: At most one request is taken per clock. Priority runs power-on, then external, then watchdog, then software, and power-on is taken on every cycle its input is high.
- R2: A request that is blocked by a higher one stays pending and is taken on a later cycle, once nothing above it is pending.
- R3: Power-on drives `board_rst` high on the edge after the request is sampled. `board_rst` falls exactly 16 edges (HOLD) after the last edge that sampled the request high. `core_state` becomes normal (2'b00) on that same edge, and `core_rst` is high whenever `board_rst` is high.
- R4: While power-on is requested or `board_rst` is high, external and software requests and traps are discarded. They are not taken later, even if they are still held after the hold ends.
- R5: `cancel_pend` is a one-cycle pulse. It follows the first edge of a power-on, and the edge on which a watchdog reset is taken. External and software resets never raise it.
- R6: A taken external reset gives a one-cycle `core_rst` pulse and never raises `board_rst`. It moves the error state (2'b01) to red (2'b10) and leaves any other state as it is.
- R7: When `trap_evt` is high, `trap_lvl` equals `trap_max` minus one and the state is not error, the next edge moves the state to error and raises a watchdog request.
- R8: A taken watchdog reset gives a one-cycle `core_rst` pulse, moves an error-state core to red, and never raises `board_rst`.
- R9: A taken software reset gives a one-cycle `core_rst` pulse and leaves `core_state` unchanged.
- R10: `cause` is one-hot and shows the last taken reset: bit 3 power-on, bit 2 external, bit 1 watchdog, bit 0 software. Controller reset (`rst_n` low) clears it and sets the state to normal.
- R11: External and software requests are taken on their rising edge. A request held high does not fire again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller itself |
| req_pwr | input | 1 | Power-on / push-button reset request (level) |
| req_ext | input | 1 | Externally initiated reset request |
| req_sw | input | 1 | Software-initiated reset request |
| trap_evt | input | 1 | A trap is taken this cycle |
| trap_lvl | input | TLW | Current trap level |
| trap_max | input | TLW | Maximum trap level |
| board_rst | output | 1 | Board-wide reset |
| core_rst | output | 1 | Core reset |
| cancel_pend | output | 1 | Cancel-pending-transactions strobe |
| core_state | output | 2 | 00 normal, 01 error, 10 red |
| cause | output | 4 | One-hot code of the last taken reset |

## Verification
The bench raises an external reset in the same cycle that the watchdog is pending. A design with the wrong priority would report the watchdog first, and one that dropped blocked requests would never report it. It raises external and software together, and holds requests high, so that a level-triggered design shows up as a repeated `core_rst`. It counts the power-on hold edge by edge. An off-by-one timer would release the board one cycle early or late. During the hold it feeds an error-level trap and fresh software edges. A design that let them through would leave the core in error or take a software reset after the board comes out of reset.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  typedef enum logic [1:0] {
    CS_NORMAL = 2'b00,
    CS_ERROR  = 2'b01,
    CS_RED    = 2'b10
  } core_state_e;

  localparam int NSRC    = 4;
  localparam int SRC_SW  = 0;
  localparam int SRC_WD  = 1;
  localparam int SRC_EXT = 2;
  localparam int SRC_POR = 3;

  // keep only the highest set bit
  function automatic logic [NSRC-1:0] pick_top(input logic [NSRC-1:0] req);
    logic [NSRC-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++)
      if (req[i]) r = NSRC'(1) << i;
    return r;
  endfunction
endpackage

// File: rtl/rrc_req_edge.sv
module rrc_req_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         flush,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend_eff
);
  for (genvar g = 0; g < N; g++) begin : g_src
    logic prev_q, pend_q;
    assign pend_eff[g] = pend_q | (req[g] & ~prev_q);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        prev_q <= req[g];
        pend_q <= flush ? 1'b0 : (pend_eff[g] & ~clr[g]);
      end
    end
  end
endmodule

// File: rtl/rrc_por_timer.sv
module rrc_por_timer #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_pwr,
  output logic busy,
  output logic first,
  output logic done
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt_q;

  assign busy  = (cnt_q != '0);
  assign first = req_pwr && !busy;
  assign done  = !req_pwr && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (req_pwr) cnt_q <= CW'(HOLD);
    else if (busy)    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/rrc_core_fsm.sv
module rrc_core_fsm
  import rrc_pkg::*;
#(
  parameter int TLW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           por_req,
  input  logic           por_hold,
  input  logic           por_done,
  input  logic           trap_evt,
  input  logic [TLW-1:0] trap_lvl,
  input  logic [TLW-1:0] trap_max,
  input  logic           take_ext,
  input  logic           take_wd,
  output core_state_e    state,
  output logic           wd_pend,
  output logic           err_entry
);
  function automatic logic at_last_level(input logic [TLW-1:0] lvl, input logic [TLW-1:0] mx);
    return lvl == TLW'(mx - 1'b1);
  endfunction

  core_state_e nstate;

  assign err_entry = trap_evt && at_last_level(trap_lvl, trap_max) &&
                     (state != CS_ERROR) && !por_req && !por_hold;

  always_comb begin
    nstate = state;
    if (por_req)
      nstate = CS_RED;
    else if (por_hold) begin
      if (por_done) nstate = CS_NORMAL;
    end else begin
      if ((take_ext || take_wd) && state == CS_ERROR) nstate = CS_RED;
      if (err_entry) nstate = CS_ERROR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= CS_NORMAL;
      wd_pend <= 1'b0;
    end else begin
      state <= nstate;
      if (por_req || por_hold) wd_pend <= 1'b0;
      else                     wd_pend <= (wd_pend & ~take_wd) | err_entry;
    end
  end
endmodule

// File: rtl/reset_request_ctrl.sv
module reset_request_ctrl
  import rrc_pkg::*;
#(
  parameter int TLW  = 3,
  parameter int HOLD = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_pwr,
  input  logic           req_ext,
  input  logic           req_sw,
  input  logic           trap_evt,
  input  logic [TLW-1:0] trap_lvl,
  input  logic [TLW-1:0] trap_max,
  output logic           board_rst,
  output logic           core_rst,
  output logic           cancel_pend,
  output logic [1:0]     core_state,
  output logic [3:0]     cause
);
  logic            por_busy, por_first, por_done;
  logic [1:0]      ext_sw_pend;
  logic [1:0]      ext_sw_clr;
  logic            wd_pend, err_entry;
  logic [NSRC-1:0] take;
  logic            core_pulse_q, cancel_q;
  logic [NSRC-1:0] cause_q;
  core_state_e     state;

  rrc_por_timer #(.HOLD(HOLD)) u_timer (
    .clk(clk), .rst_n(rst_n), .req_pwr(req_pwr),
    .busy(por_busy), .first(por_first), .done(por_done)
  );

  // bit 1 external, bit 0 software
  rrc_req_edge #(.N(2)) u_edges (
    .clk(clk), .rst_n(rst_n), .req({req_ext, req_sw}),
    .flush(req_pwr | por_busy), .clr(ext_sw_clr), .pend_eff(ext_sw_pend)
  );

  always_comb begin
    if (req_pwr)       take = NSRC'(1) << SRC_POR;
    else if (por_busy) take = '0;
    else               take = pick_top({1'b0, ext_sw_pend[1], wd_pend, ext_sw_pend[0]});
  end
  assign ext_sw_clr = {take[SRC_EXT], take[SRC_SW]};

  rrc_core_fsm #(.TLW(TLW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .por_req(req_pwr), .por_hold(por_busy),
    .por_done(por_done), .trap_evt(trap_evt), .trap_lvl(trap_lvl),
    .trap_max(trap_max), .take_ext(take[SRC_EXT]), .take_wd(take[SRC_WD]),
    .state(state), .wd_pend(wd_pend), .err_entry(err_entry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_pulse_q <= 1'b0;
      cancel_q     <= 1'b0;
      cause_q      <= '0;
    end else begin
      core_pulse_q <= take[SRC_EXT] | take[SRC_WD] | take[SRC_SW];
      cancel_q     <= por_first | take[SRC_WD];
      if (take != '0) cause_q <= take;
    end
  end

  assign board_rst   = por_busy;
  assign core_rst    = por_busy | core_pulse_q;
  assign cancel_pend = cancel_q;
  assign core_state  = state;
  assign cause       = cause_q;
endmodule

// File: rtl/rrc_checker.sv
module rrc_checker
  import rrc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_pwr,
  input logic       board_rst,
  input logic       core_rst,
  input logic       cancel_pend,
  input logic [1:0] core_state,
  input logic [3:0] cause,
  input logic [3:0] take,
  input logic       err_entry,
  input logic       wd_pend
);
  assert_one_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));
  assert_por_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_pwr |-> take == 4'b1000);
  assert_board_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_pwr |=> board_rst && cause == 4'b1000);
  assert_board_core_R3: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst |-> core_rst);
  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(board_rst) |-> core_state == CS_NORMAL && !$past(req_pwr));
  assert_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pwr || board_rst) |-> !err_entry && take[2:0] == 3'b000);
  assert_cancel_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_pend |=> !cancel_pend);
  assert_board_only_por_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(board_rst) |-> $past(req_pwr));
  assert_err_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_entry |=> core_state == CS_ERROR && wd_pend);
  assert_wd_red_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take[1] && core_state == CS_ERROR) |=> core_state == CS_RED && cancel_pend);
  assert_cause_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause));
endmodule

bind reset_request_ctrl rrc_checker u_rrc_checker (
  .clk(clk), .rst_n(rst_n), .req_pwr(req_pwr), .board_rst(board_rst),
  .core_rst(core_rst), .cancel_pend(cancel_pend), .core_state(core_state),
  .cause(cause), .take(take), .err_entry(err_entry), .wd_pend(wd_pend)
);

// File: tb/test_reset_request_ctrl.sv
module test_reset_request_ctrl;
  localparam int TLW = 3;
  localparam int NV  = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_pwr = 1'b0, req_ext = 1'b0, req_sw = 1'b0, trap_evt = 1'b0;
  logic [TLW-1:0] trap_lvl = '0, trap_max = 3'd7;
  logic board_rst, core_rst, cancel_pend;
  logic [1:0] core_state;
  logic [3:0] cause;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  reset_request_ctrl #(.TLW(TLW), .HOLD(16)) i_reset_request_ctrl (
    .clk(clk), .rst_n(rst_n), .req_pwr(req_pwr), .req_ext(req_ext),
    .req_sw(req_sw), .trap_evt(trap_evt), .trap_lvl(trap_lvl),
    .trap_max(trap_max), .board_rst(board_rst), .core_rst(core_rst),
    .cancel_pend(cancel_pend), .core_state(core_state), .cause(cause)
  );

  // stimulus {pwr,ext,sw,trap,lvl[2:0]} _ expected {board,core,cancel,state[1:0],cause[3:0]}
  localparam logic [15:0] VEC [NV] = '{
    16'b0100_000_010_00_0100,  // ext rise taken
    16'b0100_000_000_00_0100,  // ext held: no repeat
    16'b0010_000_010_00_0001,  // sw taken, state kept
    16'b0001_101_000_00_0001,  // trap below limit
    16'b0001_110_000_01_0001,  // trap at limit-1 -> error
    16'b0000_000_011_10_0010,  // watchdog taken -> red + cancel
    16'b0000_000_000_10_0010,  // strobe gone
    16'b0001_110_000_01_0010,  // red -> error again
    16'b0100_000_010_10_0100,  // ext beats pending watchdog, error->red
    16'b0000_000_011_10_0010,  // deferred watchdog now taken
    16'b0110_000_010_10_0100,  // ext and sw together: ext first
    16'b0000_000_010_10_0001,  // deferred sw
    16'b0000_000_000_10_0001   // idle
  };
  string tags [NV] = '{"R6", "R11", "R9", "R7", "R7", "R8", "R5",
                       "R7", "R1", "R2", "R1", "R2", "R10"};

  function automatic logic [8:0] observed();
    return {board_rst, core_rst, cancel_pend, core_state, cause};
  endfunction

  task automatic check(input string tag, input logic [8:0] exp);
    logic [8:0] act;
    act = observed();
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got brd/core/cncl/st/cause=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic drive(input logic p, e, s, t, input logic [2:0] l);
    req_pwr = p; req_ext = e; req_sw = s; trap_evt = t; trap_lvl = l;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check("R10 reset", 9'b000_00_0000);
    rst_n = 1'b1;
    tick();
    check("R10 idle", 9'b000_00_0000);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:9]);
      tick();
      check(tags[i], VEC[i][8:0]);
    end

    // power-on together with external and an error-level trap
    drive(1'b1, 1'b1, 1'b0, 1'b1, 3'd6);
    tick();
    check("R1 R5 por first", 9'b111_10_1000);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 3'd0);
    tick();
    check("R5 por second cycle", 9'b110_10_1000);
    // release; new sw edge and trap during the hold
    drive(1'b0, 1'b1, 1'b1, 1'b1, 3'd6);
    for (int k = 0; k < 15; k++) tick();
    check("R3 R4 hold edge 15", 9'b110_10_1000);
    tick();
    check("R3 release edge 16", 9'b000_00_1000);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 3'd0);
    tick();
    check("R4 held requests dropped", 9'b000_00_1000);

    // other trap limit
    trap_max = 3'd3;
    drive(1'b0, 1'b0, 1'b0, 1'b1, 3'd2);
    tick();
    check("R7 limit 3", 9'b000_01_1000);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 3'd0);
    tick();
    check("R8 watchdog", 9'b011_10_0010);
    tick();
    check("R5 single pulse", 9'b000_10_0010);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule